// File: doc/BRIEF.md
# Capture FIFO Threshold DMA Event Generator

This block decides when a video capture path should ask the DMA engine to drain its FIFOs. It watches the fill levels of three capture FIFOs: luma, blue chroma and red chroma. When a FIFO's level climbs to a programmed threshold, the block raises a one-cycle request event for that FIFO. It then follows the resulting transfer by counting the double-word reads the DMA engine makes from that FIFO.

Each FIFO channel has its own pending flag, busy flag and read down-counter. Only one request per channel can wait for service at a time. While a transfer runs, a second request may be raised early, but only if the FIFO level runs past twice the threshold. The two chroma FIFOs use a threshold derived from the luma threshold. A mode pin selects three-component capture or luma-only capture.

The block has no streaming data path. All of its pins are plain control and status signals. They are sampled on the rising clock edge, and every output is registered.

Top module: `vcap_dma_evtgen`

## Requirements
- R1: With nothing pending or active on a channel, a rise of its fill level from below its threshold (previous cycle) to at or above it (current cycle) raises that channel's event and sets its pending flag at the next clock edge.
- R2: An event output is high for exactly one cycle per request.
- R3: While a channel's pending flag is set, no further event is raised on that channel, even when its level crosses the threshold again.
- R4: The first read strobe on a pending, idle channel starts a service. Pending clears and busy sets, and that read counts as the first of T reads, where T is the channel threshold. Busy clears on the read that brings the count to zero.
- R5: While a channel is busy with nothing pending, a level strictly above twice its threshold raises one event and sets pending. A level equal to twice the threshold does not.
- R6: The blue and red chroma channels use the threshold (T + T mod 2) / 2, where T is the `thresh` input. For example, T = 7 gives 4.
- R7: Channels are independent. Bit 0 of every 3-bit port is luma, bit 1 is blue chroma and bit 2 is red chroma.
- R8: With `tri_mode` low, the chroma event, pending and busy outputs stay low from the next cycle on. The luma channel keeps working.
- R9: A read strobe on a channel with nothing pending and nothing busy is ignored. A later service on that channel still lasts exactly T reads.
- R10: A synchronous active-high `rst` clears all events, pending flags, busy flags and counters.
- R11: When the final read of a transfer and an above-twice-threshold level fall in the same cycle, busy clears, pending sets and the event fires, all at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tri_mode | input | 1 | 1 = three FIFOs active, 0 = luma only |
| thresh | input | THR_W | Programmed luma threshold T |
| fill_y | input | LVL_W | Luma FIFO fill level |
| fill_cb | input | LVL_W | Blue chroma FIFO fill level |
| fill_cr | input | LVL_W | Red chroma FIFO fill level |
| rd | input | 3 | Per-FIFO double-word DMA read strobes |
| evt | output | 3 | Per-FIFO DMA request event pulses |
| pend | output | 3 | Per-FIFO request waiting for service |
| busy | output | 3 | Per-FIFO transfer in progress |

## Verification
Two functions can fall in the same cycle: the last read that finishes a transfer, and the early request raised because the level has passed twice the threshold.

The bench sets this up on the luma channel. It issues T - 1 reads and then, in one cycle, drives the final read together with a level above 2T. The result is judged at the following edge: busy must be low, and both pending and the event must be high. A design that lets either action mask the other fails that check.

// File: rtl/vcap_dma_pkg.sv
package vcap_dma_pkg;
  localparam int NUM_COMP = 3;

  typedef enum logic [1:0] {
    COMP_Y  = 2'd0,
    COMP_CB = 2'd1,
    COMP_CR = 2'd2
  } comp_e;

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vcap_dma_thr_split.sv
module vcap_dma_thr_split #(
  parameter int THR_W = 8
) (
  input  logic [THR_W-1:0] thresh,
  output logic [THR_W-1:0] thr_luma,
  output logic [THR_W-1:0] thr_chroma
);
  logic [THR_W:0] rounded;

  // chroma threshold = ceil(T/2)
  always_comb begin
    rounded    = {1'b0, thresh} + {{THR_W{1'b0}}, thresh[0]};
    thr_luma   = thresh;
    thr_chroma = rounded[THR_W:1];
  end
endmodule

// File: rtl/vcap_dma_chan.sv
module vcap_dma_chan #(
  parameter int LVL_W = 8,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             rd,
  output logic             evt,
  output logic             pend,
  output logic             busy
);
  import vcap_dma_pkg::*;

  localparam int CW = wider(LVL_W, THR_W) + 2;

  logic [LVL_W-1:0] prev_level;
  logic [THR_W-1:0] left;
  logic [CW-1:0]    lvl_w, prev_w, thr_w, thr2_w;
  logic             crossed, overrun, fire, start, advance, last_rd;

  always_comb begin
    lvl_w   = CW'(level);
    prev_w  = CW'(prev_level);
    thr_w   = CW'(thr);
    thr2_w  = thr_w << 1;
    crossed = (prev_w < thr_w) && (lvl_w >= thr_w);
    overrun = lvl_w > thr2_w;
    fire    = en && !pend && ((!busy && crossed) || (busy && overrun));
    start   = en && rd && pend && !busy;
    advance = en && rd && busy;
    last_rd = (left == THR_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) prev_level <= '0;
    else     prev_level <= level;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      evt  <= 1'b0;
      pend <= 1'b0;
      busy <= 1'b0;
      left <= '0;
    end else begin
      evt <= fire;
      if (fire)       pend <= 1'b1;
      else if (start) pend <= 1'b0;
      if (start) begin
        left <= thr - THR_W'(1);
        busy <= (thr > THR_W'(1));
      end else if (advance) begin
        left <= left - THR_W'(1);
        if (last_rd) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcap_dma_evtgen.sv
module vcap_dma_evtgen #(
  parameter int LVL_W = 8,
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tri_mode,
  input  logic [THR_W-1:0] thresh,
  input  logic [LVL_W-1:0] fill_y,
  input  logic [LVL_W-1:0] fill_cb,
  input  logic [LVL_W-1:0] fill_cr,
  input  logic [2:0]       rd,
  output logic [2:0]       evt,
  output logic [2:0]       pend,
  output logic [2:0]       busy
);
  import vcap_dma_pkg::*;

  logic [THR_W-1:0] thr_luma, thr_chroma;
  logic [LVL_W-1:0] lvl_arr [NUM_COMP];

  assign lvl_arr[COMP_Y]  = fill_y;
  assign lvl_arr[COMP_CB] = fill_cb;
  assign lvl_arr[COMP_CR] = fill_cr;

  vcap_dma_thr_split #(.THR_W(THR_W)) u_split (
    .thresh     (thresh),
    .thr_luma   (thr_luma),
    .thr_chroma (thr_chroma)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_chan
    localparam bit IS_LUMA = (c == int'(COMP_Y));
    logic en_c;
    assign en_c = IS_LUMA ? 1'b1 : tri_mode;

    vcap_dma_chan #(.LVL_W(LVL_W), .THR_W(THR_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .en    (en_c),
      .thr   (IS_LUMA ? thr_luma : thr_chroma),
      .level (lvl_arr[c]),
      .rd    (rd[c]),
      .evt   (evt[c]),
      .pend  (pend[c]),
      .busy  (busy[c])
    );
  end
endmodule

// File: rtl/vcap_dma_evtgen_chk.sv
module vcap_dma_evtgen_chk (
  input logic       clk,
  input logic       rst,
  input logic       tri_mode,
  input logic [2:0] rd,
  input logic [2:0] evt,
  input logic [2:0] pend,
  input logic [2:0] busy
);
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (evt == 3'b0 && pend == 3'b0 && busy == 3'b0));

  a_r8_chroma_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(tri_mode) |-> (evt[2:1] == 2'b0 && pend[2:1] == 2'b0 && busy[2:1] == 2'b0));

  for (genvar i = 0; i < 3; i++) begin : g_ch
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> !evt[i]);

    a_r1_evt_sets_pend: assert property (@(posedge clk) disable iff (rst)
      evt[i] |-> pend[i]);

    a_r3_no_evt_while_pend: assert property (@(posedge clk) disable iff (rst)
      evt[i] |-> !$past(pend[i]));

    a_r4_busy_ends_on_read: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[i]) |-> ($past(rd[i]) || (i != 0 && !$past(tri_mode))));

    a_r4_pend_clears_on_read: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[i]) |-> ($past(rd[i]) || (i != 0 && !$past(tri_mode))));

    a_r9_idle_read_ignored: assert property (@(posedge clk) disable iff (rst)
      (rd[i] && !pend[i] && !busy[i]) |=> !busy[i]);
  end
endmodule

bind vcap_dma_evtgen vcap_dma_evtgen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tri_mode (tri_mode),
  .rd       (rd),
  .evt      (evt),
  .pend     (pend),
  .busy     (busy)
);

// File: tb/vcap_dma_evtgen_test.sv
module vcap_dma_evtgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tri_mode = 1'b1;
  logic [7:0] thresh = 8'd8;
  logic [7:0] fill_y = '0, fill_cb = '0, fill_cr = '0;
  logic [2:0] rd = '0;
  logic [2:0] evt, pend, busy;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vcap_dma_evtgen #(.LVL_W(8), .THR_W(8)) uut (
    .clk(clk), .rst(rst), .tri_mode(tri_mode), .thresh(thresh),
    .fill_y(fill_y), .fill_cb(fill_cb), .fill_cr(fill_cr),
    .rd(rd), .evt(evt), .pend(pend), .busy(busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FIFO-DMA FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] t, input logic m);
    rst = 1'b1; thresh = t; tri_mode = m;
    fill_y = 0; fill_cb = 0; fill_cr = 0; rd = 0;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    do_reset(8'd8, 1'b1);
    chk("R10 evt", evt, 3'b000);
    chk("R10 pend", pend, 3'b000);
    chk("R10 busy", busy, 3'b000);
  endtask

  task automatic t_cross_and_service();
    do_reset(8'd8, 1'b1);
    fill_y = 7; tick();
    chk("R1 below thr", evt, 3'b000);
    fill_y = 8; tick();
    chk("R1 crossing evt", evt, 3'b001);
    chk("R1 pend set", pend, 3'b001);
    tick();
    chk("R2 pulse ends", evt, 3'b000);
    fill_y = 0; tick();
    fill_y = 9; tick();
    chk("R3 no evt while pending", evt, 3'b000);
    rd = 3'b001; tick();
    chk("R4 service busy", busy, 3'b001);
    chk("R4 pend cleared", pend, 3'b000);
    repeat (6) tick();
    chk("R4 busy after 7 reads", busy, 3'b001);
    tick();
    chk("R4 done after 8 reads", busy, 3'b000);
    rd = 3'b000; tick();
  endtask

  task automatic t_idle_read();
    do_reset(8'd8, 1'b1);
    rd = 3'b001; tick(); tick();
    chk("R9 idle read busy", busy, 3'b000);
    chk("R9 idle read pend", pend, 3'b000);
    rd = 3'b000;
    fill_y = 8; tick();
    chk("R9 evt after idle reads", evt, 3'b001);
    rd = 3'b001;
    repeat (7) tick();
    chk("R9 full length kept", busy, 3'b001);
    tick();
    chk("R9 ends at T reads", busy, 3'b000);
    rd = 3'b000;
  endtask

  task automatic t_chroma();
    do_reset(8'd7, 1'b1);
    fill_cb = 3; tick();
    chk("R6 cb 3 below 4", evt, 3'b000);
    fill_cb = 4; tick();
    chk("R6 cb thr is 4", evt, 3'b010);
    rd = 3'b010;
    repeat (3) tick();
    chk("R6 cb busy after 3", busy, 3'b010);
    rd = 3'b000;
    fill_cr = 4; tick();
    chk("R7 cr independent evt", evt, 3'b100);
    chk("R7 pend only cr", pend, 3'b100);
    chk("R7 cb still busy", busy, 3'b010);
    rd = 3'b010; tick();
    chk("R6 cb done after 4", busy, 3'b000);
    rd = 3'b000; tick();
  endtask

  task automatic t_overrun();
    do_reset(8'd4, 1'b1);
    fill_y = 4; tick();
    chk("R1 evt T=4", evt, 3'b001);
    rd = 3'b001; tick();
    rd = 3'b000;
    fill_y = 8; tick();
    chk("R5 equal 2T no evt", evt, 3'b000);
    fill_y = 9; tick();
    chk("R5 overrun evt", evt, 3'b001);
    chk("R5 pend+busy", pend & busy, 3'b001);
    fill_y = 0; rd = 3'b001;
    repeat (2) tick();
    chk("R5 still busy", busy, 3'b001);
    tick();
    chk("R5 busy done", busy, 3'b000);
    chk("R5 pend kept", pend, 3'b001);
    tick();
    chk("R4 second service", busy, 3'b001);
    chk("R4 second pend clear", pend, 3'b000);
    rd = 3'b000;
  endtask

  task automatic t_coincide();
    do_reset(8'd4, 1'b1);
    fill_y = 4; tick();
    rd = 3'b001;
    repeat (3) tick();
    fill_y = 9; tick();
    chk("R11 evt", evt, 3'b001);
    chk("R11 busy cleared", busy, 3'b000);
    chk("R11 pend set", pend, 3'b001);
    rd = 3'b000; tick();
  endtask

  task automatic t_single_mode();
    do_reset(8'd4, 1'b0);
    fill_y = 5; fill_cb = 5; fill_cr = 5; tick();
    chk("R8 only luma evt", evt, 3'b001);
    chk("R8 only luma pend", pend, 3'b001);
    rd = 3'b110; tick();
    chk("R8 chroma reads no busy", busy, 3'b000);
    rd = 3'b000;
  endtask

  initial begin
    t_reset();
    t_cross_and_service();
    t_idle_read();
    t_chroma();
    t_overrun();
    t_coincide();
    t_single_mode();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FIFO-DMA FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule